// File: doc/BRIEF.md
# Asynchronous Static-Memory Slave Bridge

This block lets a microcontroller's external static-memory controller reach a small register bank inside an FPGA. To the host, the bank looks like a 16-bit asynchronous SRAM or NOR device. The address and data buses are separate pins, and every access is a single transfer. The block runs on its own FPGA clock, which has no relation to the host clock. For that reason it treats chip select, output enable and write enable as asynchronous strobes. Each strobe passes through a two-flop synchroniser. The address and data buses are delayed by the same number of stages, so their samples stay aligned with the strobes.

A write is committed on the synchronised rising edge of write enable. It uses the address and data captured while the strobe was still low, so a host that gives zero address hold is handled correctly. A read drives the data bus through a separate output-enable pin, which is meant for a tri-state pad at the chip top. The read data is produced by a registered read of the bank. Both kinds of access also appear inside the FPGA as one-cycle strobes carrying the word index.

An optional active-low wait output can be enabled with a parameter. When enabled, it holds the host off until the read data is being driven.

Top module: `sram_slave_bridge`

## Requirements
- R1: After reset, bus_doe, wr_stb and rd_stb are 0 and bus_wait_n is 1.
- R2: A write commits when write enable rises while chip select was low during the strobe. The bank holds 16 words, selected by address values 0 to 15. wr_stb is high for exactly one clock, in the third FPGA clock after the host's rising edge is first sampled. At the same time, wr_idx and wr_data show the address and data that were present during the strobe.
- R3: Once chip select and output enable are both low, bus_doe rises in the third FPGA clock. In that same clock bus_dout carries the addressed word, so read latency is 3 clocks.
- R4: When chip select or output enable returns high, bus_doe falls by the second FPGA clock edge after the change.
- R5: A write to an address of 16 or more raises no wr_stb and changes no word of the bank.
- R6: A read from an address of 16 or more drives bus_dout = 0 with bus_doe high.
- R7: While chip select is high, output enable and write enable have no effect: no strobe is raised, bus_doe stays low and no word changes.
- R8: A read may start in the same FPGA clock in which a write to the same word commits (zero bus turnaround). In that case the first driven bus_dout value is the newly written data.
- R9: With the wait option enabled, bus_wait_n is 0 during the clock before bus_doe rises and is 1 otherwise. With the option disabled (the default), bus_wait_n is always 1.
- R10: A read raises rd_stb for exactly one clock, in the same clock bus_doe rises, with rd_idx equal to the low address bits. This happens for mapped and unmapped addresses alike.
- R11: When the address and data change in the same instant that write enable rises (zero hold), the write still uses the values held during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_addr | input | ADDR_W | Host address bus |
| bus_din | input | DATA_W | Data from the host (pad input) |
| bus_dout | output | DATA_W | Read data toward the host (pad output) |
| bus_doe | output | 1 | Pad output enable for bus_dout |
| bus_wait_n | output | 1 | Active-low wait to the host |
| wr_stb | output | 1 | One-cycle internal write strobe |
| wr_idx | output | IDX_W | Word index of the committed write |
| wr_data | output | DATA_W | Data of the committed write |
| rd_stb | output | 1 | One-cycle internal read strobe |
| rd_idx | output | IDX_W | Word index of the read |

## Verification
The block has one case where two of its functions fall in the same FPGA clock: a write commit to a word, and the start of a read of that same word. The bench provokes this with a zero-turnaround transfer. It raises write enable and lowers output enable in the same instant, while chip select stays low and the address stays fixed. The synchronised write edge and the synchronised read start then reach the logic in the same cycle. In the cycle where wr_stb is high, bench_doe must also be high, and bus_dout must already equal the data just written rather than the stale word.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;
  // Bundle of the three host strobes, all active low
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/align_pipe.sv
// Plain register delay line that keeps bus samples aligned with the strobe synchroniser.
module align_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/strobe_ctrl.sv
// Two-flop synchroniser for the host strobes plus edge and window decode.
module strobe_ctrl import sram_bridge_pkg::*; (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t raw,
  output logic    cap_en,     // write strobe active with chip select: capture bus
  output logic    commit,     // synchronised rising edge of an armed write
  output logic    rd_go,      // read window seen in both synchroniser stages
  output logic    rd_start,   // synchronised falling edge of output enable
  output logic    acc_early   // read window seen in first stage only
);
  strobe_t s1, s2;
  logic    we_s3, oe_s3;
  logic    armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= STROBE_IDLE;
      s2    <= STROBE_IDLE;
      we_s3 <= 1'b1;
      oe_s3 <= 1'b1;
    end else begin
      s1    <= raw;
      s2    <= s1;
      we_s3 <= s2.we_n;
      oe_s3 <= s2.oe_n;
    end
  end

  assign cap_en    = !s2.we_n && !s2.cs_n;
  assign commit    = s2.we_n && !we_s3 && armed;
  assign rd_go     = !s1.cs_n && !s1.oe_n && !s2.cs_n && !s2.oe_n;
  assign rd_start  = !s2.oe_n && oe_s3 && !s2.cs_n;
  assign acc_early = !s1.cs_n && !s1.oe_n;

  // A write is only honoured if chip select was low while the strobe was low
  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (commit) armed <= 1'b0;
    else if (cap_en) armed <= 1'b1;
  end
endmodule

// File: rtl/reg_bank.sv
// Word bank with one write port and a registered read port (block RAM friendly).
module reg_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic              rzero,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  // Same-cycle write to the read word is forwarded
  always_ff @(posedge clk) begin
    if (rst)                     rdata <= '0;
    else if (rzero)              rdata <= '0;
    else if (we && widx == ridx) rdata <= wdata;
    else                         rdata <= mem[ridx];
  end
endmodule

// File: rtl/sram_slave_bridge.sv
module sram_slave_bridge import sram_bridge_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int REG_DEPTH = 16,
  parameter bit WAIT_EN   = 1'b0,
  localparam int IDX_W    = $clog2(REG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_wait_n,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [IDX_W-1:0]  rd_idx
);
  localparam int SYNC_DEPTH = 2;
  localparam logic [ADDR_W-1:0] MAP_LIMIT = ADDR_W'(REG_DEPTH);

  strobe_t raw_strb;
  logic cap_en, commit, rd_go, rd_start, acc_early;
  logic [ADDR_W-1:0] addr_al, cap_addr;
  logic [DATA_W-1:0] data_al, cap_data;
  logic wr_fire, rd_map;

  assign raw_strb = '{cs_n: bus_cs_n, oe_n: bus_oe_n, we_n: bus_we_n};

  strobe_ctrl u_strb (
    .clk(clk), .rst(rst), .raw(raw_strb),
    .cap_en(cap_en), .commit(commit), .rd_go(rd_go),
    .rd_start(rd_start), .acc_early(acc_early)
  );

  align_pipe #(.W(ADDR_W), .DEPTH(SYNC_DEPTH)) u_addr_al (
    .clk(clk), .rst(rst), .d(bus_addr), .q(addr_al)
  );

  align_pipe #(.W(DATA_W), .DEPTH(SYNC_DEPTH)) u_data_al (
    .clk(clk), .rst(rst), .d(bus_din), .q(data_al)
  );

  // Hold the last bus sample taken inside the write strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (cap_en) begin
      cap_addr <= addr_al;
      cap_data <= data_al;
    end
  end

  assign wr_fire = commit && (cap_addr < MAP_LIMIT);
  assign rd_map  = addr_al < MAP_LIMIT;

  reg_bank #(.DATA_W(DATA_W), .DEPTH(REG_DEPTH)) u_bank (
    .clk(clk), .rst(rst),
    .we(wr_fire), .widx(cap_addr[IDX_W-1:0]), .wdata(cap_data),
    .ridx(addr_al[IDX_W-1:0]), .rzero(!rd_map),
    .rdata(bus_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      rd_idx  <= '0;
      bus_doe <= 1'b0;
    end else begin
      wr_stb  <= wr_fire;
      rd_stb  <= rd_start;
      bus_doe <= rd_go;
      if (wr_fire) begin
        wr_idx  <= cap_addr[IDX_W-1:0];
        wr_data <= cap_data;
      end
      if (rd_start) rd_idx <= addr_al[IDX_W-1:0];
    end
  end

  if (WAIT_EN) begin : g_wait
    logic wait_q;
    always_ff @(posedge clk) begin
      if (rst) wait_q <= 1'b1;
      else     wait_q <= !(acc_early && !rd_go);
    end
    assign bus_wait_n = wait_q;
  end else begin : g_nowait
    assign bus_wait_n = 1'b1;
  end
endmodule

// File: rtl/sram_slave_bridge_chk.sv
module sram_slave_bridge_chk (
  input logic clk,
  input logic rst,
  input logic bus_cs_n,
  input logic bus_oe_n,
  input logic bus_we_n,
  input logic bus_doe,
  input logic bus_wait_n,
  input logic wr_stb,
  input logic rd_stb
);
  AST_DOE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (!$past(bus_cs_n, 2) && !$past(bus_oe_n, 2) &&
                 !$past(bus_cs_n, 3) && !$past(bus_oe_n, 3)));  // R3
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);  // R2
  AST_WR_AFTER_WE_RISE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(bus_we_n, 3) && !$past(bus_we_n, 4)));  // R2
  AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);  // R10
  AST_WAIT_NOT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> bus_wait_n);  // R9
endmodule

bind sram_slave_bridge sram_slave_bridge_chk u_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
  .bus_we_n(bus_we_n), .bus_doe(bus_doe), .bus_wait_n(bus_wait_n),
  .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/sram_slave_bridge_tb.sv
module sram_slave_bridge_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;

  logic [DATA_W-1:0] dout, dout_w;
  logic doe, doe_w, wait_n, wait_n_w;
  logic wr_stb, wr_stb_w, rd_stb, rd_stb_w;
  logic [IDX_W-1:0] wr_idx, wr_idx_w, rd_idx, rd_idx_w;
  logic [DATA_W-1:0] wr_data, wr_data_w;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] model [DEPTH];

  always #2 clk = ~clk;

  sram_slave_bridge u_dut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
    .bus_wait_n(wait_n), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_idx(rd_idx)
  );

  sram_slave_bridge #(.WAIT_EN(1'b1)) u_dut_wait (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout_w), .bus_doe(doe_w),
    .bus_wait_n(wait_n_w), .wr_stb(wr_stb_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .rd_stb(rd_stb_w), .rd_idx(rd_idx_w)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i, input int k);
    return DATA_W'((i * 16'h0F0F) ^ (16'h5A5A + k * 16'h1357));
  endfunction

  // Host write with zero hold: address and data change together with the WE rise (R11)
  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bit mapped = (a < DEPTH);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    repeat (5) tick();
    @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1; addr = ~a; din = ~d;
    tick(); tick();
    chk(wr_stb == 1'b0, "R2", wr_stb, 0);
    tick();
    if (mapped) begin
      chk(wr_stb == 1'b1, "R2", wr_stb, 1);
      chk(wr_idx == a[IDX_W-1:0] && wr_data == d, "R11", {12'h0, wr_idx, wr_data}, {12'h0, a[IDX_W-1:0], d});
      model[a[IDX_W-1:0]] = d;
    end else begin
      chk(wr_stb == 1'b0, "R5", wr_stb, 0);
    end
    tick();
    chk(wr_stb == 1'b0, "R2", wr_stb, 0);
    tick();
  endtask

  task automatic host_read(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] exp = (a < DEPTH) ? model[a[IDX_W-1:0]] : '0;
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; addr = a;
    tick();
    chk(wait_n_w == 1'b1, "R9", wait_n_w, 1);
    tick();
    chk(doe == 1'b0, "R3", doe, 0);
    chk(wait_n_w == 1'b0, "R9", wait_n_w, 0);
    tick();
    chk(doe == 1'b1, "R3", doe, 1);
    chk(dout == exp, (a < DEPTH) ? "R3" : "R6", dout, exp);
    chk(rd_stb == 1'b1 && rd_idx == a[IDX_W-1:0], "R10", {rd_stb, rd_idx}, {1'b1, a[IDX_W-1:0]});
    chk(wait_n_w == 1'b1 && wait_n == 1'b1, "R9", {wait_n_w, wait_n}, 2'b11);
    tick();
    chk(rd_stb == 1'b0, "R10", rd_stb, 0);
    @(negedge clk);
    oe_n = 1'b1; cs_n = 1'b1;
    tick(); tick();
    chk(doe == 1'b0, "R4", doe, 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) tick();
    chk(doe == 0 && wr_stb == 0 && rd_stb == 0 && wait_n == 1 && wait_n_w == 1, "R1",
        {doe, wr_stb, rd_stb, wait_n, wait_n_w}, 5'b00011);
    @(negedge clk) rst = 1'b0;
    tick(); tick();

    // Sweep every word with two data patterns
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < DEPTH; i++) host_write(ADDR_W'(i), pat(i, k));
      for (int i = DEPTH - 1; i >= 0; i--) host_read(ADDR_W'(i));
    end

    // Unmapped writes change nothing, unmapped reads return zero
    host_write(8'h10, 16'hDEAD);
    host_write(8'hFF, 16'hBEEF);
    host_write(8'h83, 16'h1234);
    host_read(8'h00);
    host_read(8'h0F);
    host_read(8'h03);
    host_read(8'h10);
    host_read(8'h47);

    // R7: strobes without chip select
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 8'h06; din = 16'hF00D;
    for (int c = 0; c < 6; c++) begin
      tick();
      chk(doe == 0 && wr_stb == 0 && rd_stb == 0, "R7", {doe, wr_stb, rd_stb}, 0);
    end
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      tick();
      chk(wr_stb == 0, "R7", wr_stb, 0);
    end
    host_read(8'h06);

    // R8: write commit and read start in the same clock, same word
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; addr = 8'h09; din = 16'hC0DE;
    repeat (5) tick();
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0; din = 16'h0000;
    tick(); tick(); tick();
    chk(wr_stb == 1 && doe == 1, "R8", {wr_stb, doe}, 2'b11);
    chk(dout == 16'hC0DE, "R8", dout, 16'hC0DE);
    chk(dout_w == 16'hC0DE, "R8", dout_w, 16'hC0DE);
    model[9] = 16'hC0DE;
    @(negedge clk);
    oe_n = 1'b1; cs_n = 1'b1;
    tick(); tick();
    chk(doe == 0, "R4", doe, 0);
    host_read(8'h09);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule